// File: doc/BRIEF.md
# RGB Blink and Slope PWM Controller

This block produces the gate signals for three LED sink switches (red, green, blue). A shared timebase tick marks one duty step. In normal mode the three colors take turns in a 48-step frame made of three 16-step phases. In flash mode all three colors pulse together in a single 16-step frame. On top of the fast PWM, a blink cycle is divided into 128 slots. Each color has its own turn-on slot and turn-off slot within that cycle. Between those slots the duty ramps up or down, one step at a time, at a rate set by a per-color slope code.

The register fields arrive as plain inputs from a register file outside the block. A master start bit clears everything and restarts the blink cycle from slot 0. When the internal PWM is disabled, the per-color switch bits drive the outputs directly. An external PWM pin can further gate any color whose mask bit is set.

Top module: `rgb_blink_pwm`

## Requirements
- R1: After reset, and while the reset is held, all three outputs are low.
- R2: While `start_i` is 0, all outputs are low one cycle later, whatever the other inputs are. Raising `start_i` restarts the blink cycle at slot 0 and clears each color's ramped duty level to 0.
- R3: When `pwm_en_i` is 0 (and `start_i` is 1), output bit c follows `sw_i[c]` one cycle later. Bit 0 is red, bit 1 is green, bit 2 is blue.
- R4: In normal mode (`flash_en_i`=0) the frame is 48 ticks long, made of three 16-tick phases in the order red, green, blue. A color is high for the first L ticks of its own phase, where L is its current level. This gives L/48 on-time, and no two outputs are ever high together.
- R5: In flash mode the frame is 16 ticks long. Every color is high for the first L ticks of each frame, with all colors in the same phase. Level 15 gives 15/16 on-time.
- R6: When a color's ON and OFF positions are both 0, its level equals its duty code at once, and its slope code has no effect.
- R7: When a color's ON and OFF positions are equal and not 0, its level is held at 0.
- R8: Each blink slot lasts `SLOT_BASE << cycle_sel_i` ticks. The cycle codes 0, 1, 2 and 3 select base lengths of x1, x2, x4 and x8. A color targets its duty while the slot lies in [ON, OFF); when ON > OFF this window wraps past slot 127. Outside the window the color targets 0.
- R9: The level moves one step toward its target every `RAMP_TICKS*(2*slope+1)` ticks. A full ramp therefore takes a time proportional to the target duty and does not depend on the cycle code.
- R10: For each color with `ext_mask_i[c]`=1, the output is ANDed with `ext_pwm_i`. Colors whose mask bit is 0 are unaffected by that pin.
- R11: Without a tick, the PWM step, phase, blink slot and ramp levels hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one per duty step |
| start_i | input | 1 | Master enable; a rising edge restarts the blink cycle |
| pwm_en_i | input | 1 | 1 = internal PWM and blinking, 0 = direct switch control |
| flash_en_i | input | 1 | 1 = single common phase, 0 = three-phase |
| cycle_sel_i | input | 2 | Blink cycle length code |
| sw_i | input | 3 | Direct switch bits {blue, green, red} |
| ext_mask_i | input | 3 | Per-color enable for external PWM gating |
| ext_pwm_i | input | 1 | External PWM / enable pin |
| duty_i | input | 12 | 4-bit duty per color, red in bits 3:0 |
| slope_i | input | 12 | 4-bit slope per color, red in bits 3:0 |
| on_pos_i | input | 21 | 7-bit turn-on slot per color, red in bits 6:0 |
| off_pos_i | input | 21 | 7-bit turn-off slot per color, red in bits 6:0 |
| led_o | output | 3 | Switch gates {blue, green, red} |

## Verification
The embedded properties assume that the register fields change only between test scenarios, never partway through a ramp. They also assume that the tick is a level sampled each clock, so a run of ticks counts one step per cycle. The stimulus changes all register fields only with `start_i` low, or while the block sits in a steady mode. It then measures on-times over windows that are whole multiples of the 16- or 48-tick frame, so the counts do not depend on frame alignment. Blink and ramp timing are checked at points chosen well inside a slot, away from any ON/OFF edge or ramp end.

// File: rtl/rgb_pkg.sv
package rgb_pkg;
  localparam int NCOL    = 3;
  localparam int DUTY_W  = 4;
  localparam int STEP_W  = DUTY_W;
  localparam int SLOPE_W = 4;
  localparam int POS_W   = 7;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;
endpackage

// File: rtl/rgb_timebase.sv
module rgb_timebase
  import rgb_pkg::*;
#(
  parameter int SLOT_BASE = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [1:0]        cycle_sel,
  output logic [STEP_W-1:0] step_o,
  output phase_e            phase_o,
  output logic [POS_W-1:0]  slot_o
);
  localparam int SUB_W = $clog2(SLOT_BASE * 8 + 1);

  logic [STEP_W-1:0] step_q, step_d;
  phase_e            phase_q, phase_d;
  logic [POS_W-1:0]  slot_q, slot_d;
  logic [SUB_W-1:0]  sub_q, sub_d, sub_last;

  assign sub_last = (SUB_W'(SLOT_BASE) << cycle_sel) - SUB_W'(1);

  always_comb begin
    step_d  = step_q;
    phase_d = phase_q;
    slot_d  = slot_q;
    sub_d   = sub_q;
    if (!run) begin
      step_d  = '0;
      phase_d = PH_RED;
      slot_d  = '0;
      sub_d   = '0;
    end else if (tick) begin
      step_d = step_q + STEP_W'(1);
      if (step_q == {STEP_W{1'b1}}) begin
        case (phase_q)
          PH_RED:  phase_d = PH_GRN;
          PH_GRN:  phase_d = PH_BLU;
          default: phase_d = PH_RED;
        endcase
      end
      if (sub_q >= sub_last) begin
        sub_d  = '0;
        slot_d = slot_q + POS_W'(1);
      end else begin
        sub_d = sub_q + SUB_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      phase_q <= PH_RED;
      slot_q  <= '0;
      sub_q   <= '0;
    end else begin
      step_q  <= step_d;
      phase_q <= phase_d;
      slot_q  <= slot_d;
      sub_q   <= sub_d;
    end
  end

  assign step_o  = step_q;
  assign phase_o = phase_q;
  assign slot_o  = slot_q;

  // R11
  tb_hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> ($stable(step_o) && $stable(slot_o) && $stable(phase_o)));

  // R2
  tb_restart_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (slot_o == '0 && step_o == '0));
endmodule

// File: rtl/rgb_ramp.sv
module rgb_ramp
  import rgb_pkg::*;
#(
  parameter int RAMP_TICKS = 661
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [DUTY_W-1:0]  duty,
  input  logic [SLOPE_W-1:0] slope,
  input  logic [POS_W-1:0]   on_pos,
  input  logic [POS_W-1:0]   off_pos,
  input  logic [POS_W-1:0]   slot,
  output logic [DUTY_W-1:0]  level_o
);
  localparam int MAX_MULT = 2 * (2 ** SLOPE_W - 1) + 1;
  localparam int RW       = $clog2(RAMP_TICKS * MAX_MULT + 1);

  logic [DUTY_W-1:0] level_q, level_d, target;
  logic [RW-1:0]     cnt_q, cnt_d, ivl_last;
  logic              steady, dark, want;

  assign steady   = (on_pos == '0) && (off_pos == '0);
  assign dark     = (on_pos == off_pos) && !steady;
  assign want     = (on_pos < off_pos) ? (slot >= on_pos && slot < off_pos)
                                       : (slot >= on_pos || slot < off_pos);
  assign target   = want ? duty : '0;
  assign ivl_last = RW'(RAMP_TICKS) * RW'({slope, 1'b1}) - RW'(1);

  always_comb begin
    level_d = level_q;
    cnt_d   = cnt_q;
    if (!run || dark) begin
      level_d = '0;
      cnt_d   = '0;
    end else if (steady) begin
      level_d = duty;
      cnt_d   = '0;
    end else if (tick) begin
      if (level_q == target) begin
        cnt_d = '0;
      end else if (cnt_q >= ivl_last) begin
        cnt_d   = '0;
        level_d = (level_q < target) ? level_q + DUTY_W'(1)
                                     : level_q - DUTY_W'(1);
      end else begin
        cnt_d = cnt_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      cnt_q   <= '0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level_o = level_q;

  // R9
  tb_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !steady && !dark) |=>
      (level_q == $past(level_q) ||
       level_q == DUTY_W'($past(level_q) + DUTY_W'(1)) ||
       level_q == DUTY_W'($past(level_q) - DUTY_W'(1))));

  // R11
  tb_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !steady && !dark) |=> $stable(level_q));

  // R7
  tb_dark_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dark |=> (level_q == '0));
endmodule

// File: rtl/rgb_blink_pwm.sv
module rgb_blink_pwm
  import rgb_pkg::*;
#(
  parameter int SLOT_BASE  = 625,
  parameter int RAMP_TICKS = 661
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_i,
  input  logic                       start_i,
  input  logic                       pwm_en_i,
  input  logic                       flash_en_i,
  input  logic [1:0]                 cycle_sel_i,
  input  logic [NCOL-1:0]            sw_i,
  input  logic [NCOL-1:0]            ext_mask_i,
  input  logic                       ext_pwm_i,
  input  logic [NCOL*DUTY_W-1:0]     duty_i,
  input  logic [NCOL*SLOPE_W-1:0]    slope_i,
  input  logic [NCOL*POS_W-1:0]      on_pos_i,
  input  logic [NCOL*POS_W-1:0]      off_pos_i,
  output logic [NCOL-1:0]            led_o
);
  logic [STEP_W-1:0] step_w;
  phase_e            phase_w;
  logic [POS_W-1:0]  slot_w;
  logic [NCOL-1:0]   led_d, led_q;

  rgb_timebase #(.SLOT_BASE(SLOT_BASE)) tb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (start_i),
    .tick      (tick_i),
    .cycle_sel (cycle_sel_i),
    .step_o    (step_w),
    .phase_o   (phase_w),
    .slot_o    (slot_w)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam logic [1:0] PH_C = 2'(c);
    logic [DUTY_W-1:0] level;
    logic              in_phase, pwm_gate, raw, ext_ok;

    rgb_ramp #(.RAMP_TICKS(RAMP_TICKS)) ramp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (start_i),
      .tick    (tick_i),
      .duty    (duty_i[c*DUTY_W +: DUTY_W]),
      .slope   (slope_i[c*SLOPE_W +: SLOPE_W]),
      .on_pos  (on_pos_i[c*POS_W +: POS_W]),
      .off_pos (off_pos_i[c*POS_W +: POS_W]),
      .slot    (slot_w),
      .level_o (level)
    );

    assign in_phase = flash_en_i || (phase_w == phase_e'(PH_C));
    assign pwm_gate = in_phase && (step_w < level);
    assign raw      = pwm_en_i ? pwm_gate : sw_i[c];
    assign ext_ok   = !ext_mask_i[c] || ext_pwm_i;
    assign led_d[c] = start_i && raw && ext_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= '0;
    else        led_q <= led_d;
  end

  assign led_o = led_q;

  // R2
  tb_master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (led_o == '0));

  // R3
  tb_direct_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !pwm_en_i && ext_mask_i == '0) |=> (led_o == $past(sw_i)));

  // R4
  tb_one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && pwm_en_i && !flash_en_i) |=> $onehot0(led_o));

  // R10
  tb_ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mask_i[0] && !ext_pwm_i) |=> !led_o[0]);
endmodule

// File: tb/rgb_blink_pwm_tb.sv
module rgb_blink_pwm_tb_top;
  import rgb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SLOT_B     = 2;
  localparam int RAMP_B     = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, start, pwm_en, flash_en, ext_pwm;
  logic [1:0] cycle_sel;
  logic [NCOL-1:0] sw, ext_mask;
  logic [NCOL*DUTY_W-1:0]  duty;
  logic [NCOL*SLOPE_W-1:0] slope;
  logic [NCOL*POS_W-1:0]   on_pos, off_pos;
  logic [NCOL-1:0] led;

  int n_chk  = 0;
  int n_fail = 0;
  int cr, cg, cb, cov, cdiff, ctog;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_blink_pwm #(.SLOT_BASE(SLOT_B), .RAMP_TICKS(RAMP_B)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start),
    .pwm_en_i(pwm_en), .flash_en_i(flash_en), .cycle_sel_i(cycle_sel),
    .sw_i(sw), .ext_mask_i(ext_mask), .ext_pwm_i(ext_pwm),
    .duty_i(duty), .slope_i(slope), .on_pos_i(on_pos), .off_pos_i(off_pos),
    .led_o(led)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_col(input int c, input int d, input int s, input int on, input int off);
    duty[c*DUTY_W +: DUTY_W]    = DUTY_W'(d);
    slope[c*SLOPE_W +: SLOPE_W] = SLOPE_W'(s);
    on_pos[c*POS_W +: POS_W]    = POS_W'(on);
    off_pos[c*POS_W +: POS_W]   = POS_W'(off);
  endtask

  task automatic set_all(input int d, input int s, input int on, input int off);
    for (int c = 0; c < NCOL; c++) set_col(c, d, s, on, off);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    start = 1'b0;
    wait_n(2);
    start = 1'b1;
  endtask

  task automatic count_win(input int n);
    logic [NCOL-1:0] prev;
    cr = 0; cg = 0; cb = 0; cov = 0; cdiff = 0; ctog = 0;
    prev = led;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cr += int'(led[0]); cg += int'(led[1]); cb += int'(led[2]);
      if ($countones(led) > 1) cov++;
      if (led[0] != led[1]) cdiff++;
      if (led != prev) ctog++;
      prev = led;
    end
  endtask

  task automatic t_reset();
    wait_n(1);
    check(led == '0, "R1 reset", int'(led), 0);
  endtask

  task automatic t_master_off();
    pwm_en = 1'b0; sw = 3'b111; start = 1'b0;
    wait_n(3);
    check(led == '0, "R2 start low", int'(led), 0);
  endtask

  task automatic t_direct();
    pwm_en = 1'b0; sw = 3'b101; start = 1'b1;
    count_win(20);
    check(cr == 20 && cb == 20, "R3 direct red/blue", cr + cb, 40);
    check(cg == 0, "R3 direct green", cg, 0);
  endtask

  task automatic t_normal();
    pwm_en = 1'b1; flash_en = 1'b0;
    set_all(15, 0, 0, 0);
    restart();
    wait_n(2);
    count_win(10);
    check(cr == 10 && cg == 0 && cb == 0, "R4 red phase first", cr*100 + cg*10 + cb, 1000);
    set_col(0, 15, 9, 0, 0); set_col(1, 8, 9, 0, 0); set_col(2, 1, 9, 0, 0);
    wait_n(4);
    count_win(480);
    check(cr == 150, "R4 red 15/48", cr, 150);
    check(cg == 80,  "R4 green 8/48", cg, 80);
    check(cb == 10,  "R4 blue 1/48", cb, 10);
    check(cov == 0,  "R4 no overlap", cov, 0);
  endtask

  task automatic t_flash();
    pwm_en = 1'b1; flash_en = 1'b1;
    set_col(0, 15, 0, 0, 0); set_col(1, 15, 0, 0, 0); set_col(2, 7, 0, 0, 0);
    wait_n(4);
    count_win(160);
    check(cr == 150 && cg == 150, "R5 flash 15/16", cr + cg, 300);
    check(cb == 70, "R5 flash 7/16", cb, 70);
    check(cdiff == 0, "R5 common phase", cdiff, 0);
    set_all(0, 0, 0, 0);
    wait_n(4);
    count_win(64);
    check(cr + cg + cb == 0, "R5 duty zero", cr + cg + cb, 0);
  endtask

  task automatic t_steady_dark();
    pwm_en = 1'b1; flash_en = 1'b1; cycle_sel = 2'd0;
    set_all(15, 15, 0, 0);
    restart();
    wait_n(3);
    count_win(16);
    check(cr == 15, "R6 steady ignores slope", cr, 15);
    set_all(15, 0, 5, 5);
    restart();
    count_win(300);
    check(cr + cg + cb == 0, "R7 equal nonzero on/off dark", cr + cg + cb, 0);
  endtask

  task automatic t_blink();
    pwm_en = 1'b1; flash_en = 1'b1;
    cycle_sel = 2'd0;
    set_all(15, 0, 0, 64);
    restart();
    wait_n(300);
    count_win(16);
    check(cr == 15, "R8 cycle code 0 back on", cr, 15);
    cycle_sel = 2'd1;
    restart();
    wait_n(300);
    count_win(16);
    check(cr == 0, "R8 cycle code 1 still off", cr, 0);
    cycle_sel = 2'd0;
    set_all(15, 0, 96, 32);
    restart();
    wait_n(20);
    count_win(16);
    check(cr == 15, "R8 wrapped window on", cr, 15);
    wait_n(114);
    count_win(16);
    check(cr == 0, "R8 wrapped window off", cr, 0);
  endtask

  task automatic t_slope();
    pwm_en = 1'b1; flash_en = 1'b1; cycle_sel = 2'd3;
    set_all(15, 7, 1, 100);
    restart();
    wait_n(116);
    count_win(16);
    check(cr > 0 && cr < 15, "R9 slope 7 mid ramp", cr, 7);
    wait_n(184);
    count_win(16);
    check(cr == 15, "R9 slope 7 ramp done", cr, 15);
    set_all(4, 7, 1, 100);
    restart();
    wait_n(116);
    count_win(16);
    check(cr == 4, "R9 ramp time scales with target", cr, 4);
    set_all(15, 0, 1, 100);
    restart();
    wait_n(60);
    count_win(16);
    check(cr == 15, "R9 slope 0 fast", cr, 15);
  endtask

  task automatic t_ext();
    pwm_en = 1'b1; flash_en = 1'b0; cycle_sel = 2'd0;
    set_all(15, 0, 0, 0);
    ext_mask = 3'b001; ext_pwm = 1'b0;
    restart();
    wait_n(4);
    count_win(480);
    check(cr == 0, "R10 masked red gated off", cr, 0);
    check(cg == 150, "R10 unmasked green", cg, 150);
    ext_pwm = 1'b1;
    wait_n(2);
    count_win(480);
    check(cr == 150, "R10 pin high passes red", cr, 150);
    ext_pwm = 1'b0; pwm_en = 1'b0; sw = 3'b111;
    wait_n(2);
    count_win(20);
    check(cr == 0 && cg == 20, "R10 gating in direct mode", cr*100 + cg, 20);
    ext_mask = 3'b000; ext_pwm = 1'b1;
  endtask

  task automatic t_no_tick();
    pwm_en = 1'b1; flash_en = 1'b0;
    set_all(8, 0, 0, 0);
    restart();
    wait_n(30);
    tick = 1'b0;
    wait_n(2);
    count_win(60);
    check(ctog == 0, "R11 frozen without tick", ctog, 0);
    tick = 1'b1;
    count_win(96);
    check(cr == 16, "R11 resumes with tick", cr, 16);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tick = 1'b1; start = 1'b0; pwm_en = 1'b1; flash_en = 1'b0;
    cycle_sel = 2'd0; sw = '0; ext_mask = '0; ext_pwm = 1'b1;
    set_all(0, 0, 0, 0);
    wait_n(3);
    check(led == '0, "R1 during reset", int'(led), 0);
    rst_n = 1'b1;
    t_reset();
    t_master_off();
    t_direct();
    t_normal();
    t_flash();
    t_steady_dark();
    t_blink();
    t_slope();
    t_ext();
    t_no_tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule